// File: doc/BRIEF.md
# System Controller with Dual Compare Timers

This block is the small housekeeping controller of an SoC. It sits on a plain 32-bit register bus with a byte address, a write strobe and a combinational read path. It groups four functions in one fixed sixteen-word window. The first is a GPIO group: a sampled input word, a driven output word and an interrupt mask. The second is a pair of identical up-counting compare timers. The third is a command word that can ask the platform to power down. The fourth is a pair of read-only identity words, a capability word and a system identifier. Writing the identifier word asks for a full system reset.

Each timer counts up from zero, one step per clock, while it is enabled. When its count equals its compare value, it pulses its interrupt and returns to zero. A timer in one-shot mode also turns itself off. A timer in auto-restart mode keeps running. The GPIO interrupt is a level output. It stays high while any unmasked input bit has changed and software has not yet acknowledged that change.

Top module: `sys_ctrl`

## Requirements
- R1: The word index is `busAddr[5:2]`, and `busAddr[1:0]` is ignored. The map is: 0 GPIO in, 1 GPIO out, 2 GPIO mask, 4/5/6 timer 0 control/compare/count, 8/9/10 timer 1 control/compare/count, 13 command, 14 capabilities, 15 system ID. Indices 3, 7, 11 and 12 always read zero, and writes to them change nothing.
- R2: While `rstN` is low and after it rises, the following hold until written: the command word reads 0x1, the system ID reads `SYS_ID` (default 0x10014D31), capabilities read `CAPS` (default 0), GPIO in reads `STRAP` (default 0x1), and every other register reads 0 with both timers stopped.
- R3: GPIO in takes the `gpioIn` pins on every clock and is read-only. Capabilities are read-only, so a write to index 14 leaves its value unchanged.
- R4: GPIO out and GPIO mask are read/write. GPIO out drives the `gpioOut` port from the clock edge that writes it.
- R5: A pending bit sets when its GPIO in bit changes. A write to index 0 clears the pending bits where the data has ones, but a change in the same cycle wins. `gpioIrq` = OR of (pending AND mask), so a write of zero to the mask drops it on the next cycle.
- R6: In a timer control word, bit 0 is enable and bit 1 is auto-restart, and they read back in those positions. An enabled timer adds one to its count on every clock. The count register reads the current count.
- R7: At a clock edge where an enabled timer's count equals its compare value, the count becomes 0 and the timer's interrupt is high for exactly the following cycle.
- R8: On such a match with auto-restart clear, the enable bit clears and the count stays at 0.
- R9: With auto-restart set, the timer keeps running, so the interrupt pulses every compare+1 clocks.
- R10: A write to a count register loads `min(data, compare)`, and it takes priority over counting and match handling in that cycle.
- R11: A write to index 13 whose low 16 bits are 0x000E makes `shutdownReq` high for the next cycle only. Other values give no pulse.
- R12: Any write to index 15 makes `resetReq` high for the next cycle only, and the identifier value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timers step once per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte address of the register access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| gpioIn | input | GPIO_W | GPIO input pins |
| gpioOut | output | GPIO_W | GPIO output pins |
| gpioIrq | output | 1 | GPIO interrupt level |
| timer0Irq | output | 1 | Timer 0 match pulse |
| timer1Irq | output | 1 | Timer 1 match pulse |
| shutdownReq | output | 1 | Shutdown request pulse |
| resetReq | output | 1 | System reset request pulse |

## Verification
Several behaviours are checked on every cycle. The cause and one-cycle timing of both request pulses are checked. Reserved words must read zero, and the identifier and ready words must read their fixed values. A mask write of zero must silence the GPIO interrupt. Other behaviours are checked only by the bench's scenarios, against a behavioural model: timer counting, the one-shot enable clear, the auto-restart period, count clipping, write priority over counting, and the pending/acknowledge race on GPIO.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W = 4;
  localparam int ADDR_W = IDX_W + 2;
  localparam int NUM_TIMERS = 2;
  localparam int TIMER_STRIDE = 4;
  localparam int TIMER_BASE = 4;

  localparam logic [IDX_W-1:0] IDX_GPIO_IN  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_GPIO_OUT = 4'd1;
  localparam logic [IDX_W-1:0] IDX_GPIO_IEN = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CMD      = 4'd13;
  localparam logic [IDX_W-1:0] IDX_CAPS     = 4'd14;
  localparam logic [IDX_W-1:0] IDX_SYSID    = 4'd15;

  localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;
  localparam logic [DATA_W-1:0] CMD_READY = 32'h1;

  typedef struct packed {
    logic gpioOutWr;
    logic gpioIenWr;
    logic gpioAckWr;
    logic [NUM_TIMERS-1:0] ctrlWr;
    logic [NUM_TIMERS-1:0] cmpWr;
    logic [NUM_TIMERS-1:0] cntWr;
    logic shutdownHit;
    logic sysResetHit;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic [IDX_W-1:0] timerIdx(input int t, input int off);
    return IDX_W'(TIMER_BASE + TIMER_STRIDE * t + off);
  endfunction
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [15:0]       cmdLow,
  output strobe_t           stb
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = busAddr[ADDR_W-1:2];
    stb = '0;
    stb.rdIdx = idx;
    if (busWrite) begin
      stb.gpioOutWr   = (idx == IDX_GPIO_OUT);
      stb.gpioIenWr   = (idx == IDX_GPIO_IEN);
      stb.gpioAckWr   = (idx == IDX_GPIO_IN);
      stb.shutdownHit = (idx == IDX_CMD) && (cmdLow == SHUTDOWN_CODE);
      stb.sysResetHit = (idx == IDX_SYSID);
      for (int t = 0; t < NUM_TIMERS; t++) begin
        stb.ctrlWr[t] = (idx == timerIdx(t, 0));
        stb.cmpWr[t]  = (idx == timerIdx(t, 1));
        stb.cntWr[t]  = (idx == timerIdx(t, 2));
      end
    end
  end
endmodule

// File: rtl/sys_ctrl_timer.sv
module sys_ctrl_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             cmpWr,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] wdata,
  output logic             enable,
  output logic             autoRestart,
  output logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic hit;
  logic [CNT_W-1:0] clipped;

  assign hit = enable && (count == compare);
  assign clipped = (wdata > compare) ? compare : wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable      <= 1'b0;
      autoRestart <= 1'b0;
      compare     <= '0;
      count       <= '0;
      irq         <= 1'b0;
    end else begin
      irq <= hit;
      if (ctrlWr) begin
        enable      <= wdata[0];
        autoRestart <= wdata[1];
      end else if (hit && !autoRestart) begin
        enable <= 1'b0;
      end
      if (cmpWr) compare <= wdata;
      if (cntWr)       count <= clipped;
      else if (hit)    count <= '0;
      else if (enable) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
#(
  parameter int GPIO_W = 8,
  parameter logic [DATA_W-1:0] CAPS = 32'h0,
  parameter logic [DATA_W-1:0] SYS_ID = 32'h10014D31,
  parameter logic [GPIO_W-1:0] STRAP = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [GPIO_W-1:0]     gpioIn,
  output logic [DATA_W-1:0]     rdata,
  output logic [GPIO_W-1:0]     gpioOut,
  output logic                  gpioIrq,
  output logic [NUM_TIMERS-1:0] timerIrq,
  output logic                  shutdownReq,
  output logic                  resetReq
);
  logic [GPIO_W-1:0] gpioInQ, gpioIen, pending, ackMask;
  logic [NUM_TIMERS-1:0] tEnable, tAuto;
  logic [DATA_W-1:0] tCompare [NUM_TIMERS];
  logic [DATA_W-1:0] tCount [NUM_TIMERS];

  assign ackMask = stb.gpioAckWr ? wdata[GPIO_W-1:0] : '0;
  assign gpioIrq = |(pending & gpioIen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpioInQ     <= STRAP;
      gpioOut     <= '0;
      gpioIen     <= '0;
      pending     <= '0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      gpioInQ     <= gpioIn;
      pending     <= (pending & ~ackMask) | (gpioInQ ^ gpioIn);
      shutdownReq <= stb.shutdownHit;
      resetReq    <= stb.sysResetHit;
      if (stb.gpioOutWr) gpioOut <= wdata[GPIO_W-1:0];
      if (stb.gpioIenWr) gpioIen <= wdata[GPIO_W-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    sys_ctrl_timer #(.CNT_W(DATA_W)) u_timer (
      .clk(clk),
      .rstN(rstN),
      .ctrlWr(stb.ctrlWr[t]),
      .cmpWr(stb.cmpWr[t]),
      .cntWr(stb.cntWr[t]),
      .wdata(wdata),
      .enable(tEnable[t]),
      .autoRestart(tAuto[t]),
      .compare(tCompare[t]),
      .count(tCount[t]),
      .irq(timerIrq[t])
    );
  end

  always_comb begin
    rdata = '0;
    case (stb.rdIdx)
      IDX_GPIO_IN:  rdata = DATA_W'(gpioInQ);
      IDX_GPIO_OUT: rdata = DATA_W'(gpioOut);
      IDX_GPIO_IEN: rdata = DATA_W'(gpioIen);
      IDX_CMD:      rdata = CMD_READY;
      IDX_CAPS:     rdata = CAPS;
      IDX_SYSID:    rdata = SYS_ID;
      default:      rdata = '0;
    endcase
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (stb.rdIdx == timerIdx(t, 0)) rdata = DATA_W'({tAuto[t], tEnable[t]});
      if (stb.rdIdx == timerIdx(t, 1)) rdata = tCompare[t];
      if (stb.rdIdx == timerIdx(t, 2)) rdata = tCount[t];
    end
  end
endmodule

// File: rtl/sys_ctrl.sv
module sys_ctrl
  import sys_ctrl_pkg::*;
#(
  parameter int GPIO_W = 8,
  parameter logic [31:0] CAPS = 32'h0,
  parameter logic [31:0] SYS_ID = 32'h10014D31,
  parameter logic [GPIO_W-1:0] STRAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [GPIO_W-1:0] gpioIn,
  output logic [GPIO_W-1:0] gpioOut,
  output logic              gpioIrq,
  output logic              timer0Irq,
  output logic              timer1Irq,
  output logic              shutdownReq,
  output logic              resetReq
);
  strobe_t stb;
  logic [NUM_TIMERS-1:0] timerIrq;

  sys_ctrl_decode u_decode (
    .busAddr(busAddr),
    .busWrite(busWrite),
    .cmdLow(busWdata[15:0]),
    .stb(stb)
  );

  sys_ctrl_regs #(
    .GPIO_W(GPIO_W), .CAPS(CAPS), .SYS_ID(SYS_ID), .STRAP(STRAP)
  ) u_regs (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wdata(busWdata),
    .gpioIn(gpioIn),
    .rdata(busRdata),
    .gpioOut(gpioOut),
    .gpioIrq(gpioIrq),
    .timerIrq(timerIrq),
    .shutdownReq(shutdownReq),
    .resetReq(resetReq)
  );

  assign timer0Irq = timerIrq[0];
  assign timer1Irq = timerIrq[1];
endmodule

// File: rtl/sys_ctrl_checker.sv
module sys_ctrl_checker #(
  parameter logic [31:0] SYS_ID = 32'h10014D31
) (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  busAddr,
  input logic        busWrite,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        gpioIrq,
  input logic        shutdownReq,
  input logic        resetReq
);
  logic [3:0] idx;
  logic shutCmd, idWrite;
  assign idx = busAddr[5:2];
  assign shutCmd = busWrite && (idx == 4'd13) && (busWdata[15:0] == 16'h000E);
  assign idWrite = busWrite && (idx == 4'd15);

  assert_shutdown_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    shutCmd |=> shutdownReq);
  assert_shutdown_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(shutCmd));
  assert_reset_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    idWrite |=> resetReq);
  assert_reset_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(idWrite));
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (idx == 4'd3 || idx == 4'd7 || idx == 4'd11 || idx == 4'd12) |-> busRdata == 32'h0);
  assert_ident_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idx == 4'd15) |-> busRdata == SYS_ID);
  assert_cmd_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idx == 4'd13) |-> busRdata == 32'h1);
  assert_mask_silences_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && idx == 4'd2 && busWdata == 32'h0) |=> !gpioIrq);
endmodule

bind sys_ctrl sys_ctrl_checker #(.SYS_ID(SYS_ID)) u_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busWdata(busWdata), .busRdata(busRdata), .gpioIrq(gpioIrq),
  .shutdownReq(shutdownReq), .resetReq(resetReq)
);

// File: tb/sys_ctrl_test.sv
`timescale 1ns/1ps
module sys_ctrl_test;
  localparam logic [31:0] EXP_ID = 32'h10014D31;
  localparam logic [31:0] EXP_CAPS = 32'h0;
  localparam logic [7:0] EXP_STRAP = 8'h01;

  logic clk = 1'b0;
  logic rstN;
  logic [5:0] busAddr;
  logic busWrite;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [7:0] gpioIn;
  logic [7:0] gpioOut;
  logic gpioIrq, timer0Irq, timer1Irq, shutdownReq, resetReq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // behavioural model state
  logic [7:0] mGin, mGout, mGen, mPend;
  logic mEn [2];
  logic mAu [2];
  logic mTirq [2];
  logic [31:0] mCmp [2];
  logic [31:0] mCnt [2];
  logic mShut, mRst;

  always #2 clk = ~clk;

  sys_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .gpioIn(gpioIn),
    .gpioOut(gpioOut), .gpioIrq(gpioIrq), .timer0Irq(timer0Irq),
    .timer1Irq(timer1Irq), .shutdownReq(shutdownReq), .resetReq(resetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mGin = EXP_STRAP; mGout = 0; mGen = 0; mPend = 0; mShut = 0; mRst = 0;
    for (int t = 0; t < 2; t++) begin
      mEn[t] = 0; mAu[t] = 0; mTirq[t] = 0; mCmp[t] = 0; mCnt[t] = 0;
    end
  endtask

  function automatic logic [31:0] modelRead(input int idx);
    case (idx)
      0: return {24'h0, mGin};
      1: return {24'h0, mGout};
      2: return {24'h0, mGen};
      4: return {30'h0, mAu[0], mEn[0]};
      5: return mCmp[0];
      6: return mCnt[0];
      8: return {30'h0, mAu[1], mEn[1]};
      9: return mCmp[1];
      10: return mCnt[1];
      13: return 32'h1;
      14: return EXP_CAPS;
      15: return EXP_ID;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelStep();
    int idx;
    logic hit;
    logic [31:0] oldCmp;
    if (!rstN) begin
      modelReset();
      return;
    end
    idx = int'(busAddr) / 4;
    mPend = (mPend & ~((busWrite && idx == 0) ? busWdata[7:0] : 8'h0)) | (mGin ^ gpioIn);
    mGin = gpioIn;
    if (busWrite && idx == 1) mGout = busWdata[7:0];
    if (busWrite && idx == 2) mGen = busWdata[7:0];
    for (int t = 0; t < 2; t++) begin
      hit = mEn[t] && (mCnt[t] == mCmp[t]);
      mTirq[t] = hit;
      oldCmp = mCmp[t];
      if (busWrite && idx == 4 + 4 * t + 2)
        mCnt[t] = (busWdata > oldCmp) ? oldCmp : busWdata;
      else if (hit) mCnt[t] = 0;
      else if (mEn[t]) mCnt[t] = mCnt[t] + 1;
      if (busWrite && idx == 4 + 4 * t) begin
        mEn[t] = busWdata[0]; mAu[t] = busWdata[1];
      end else if (hit && !mAu[t]) mEn[t] = 0;
      if (busWrite && idx == 4 + 4 * t + 1) mCmp[t] = busWdata;
    end
    mShut = busWrite && idx == 13 && busWdata[15:0] == 16'h000E;
    mRst = busWrite && idx == 15;
  endtask

  task automatic compareAll();
    check("R1 read data", busRdata, modelRead(int'(busAddr) / 4));
    check("R4 gpioOut", {24'h0, gpioOut}, {24'h0, mGout});
    check("R5 gpioIrq", {31'h0, gpioIrq}, {31'h0, |(mPend & mGen)});
    check("R7 timer0Irq", {31'h0, timer0Irq}, {31'h0, mTirq[0]});
    check("R7 timer1Irq", {31'h0, timer1Irq}, {31'h0, mTirq[1]});
    check("R11 shutdownReq", {31'h0, shutdownReq}, {31'h0, mShut});
    check("R12 resetReq", {31'h0, resetReq}, {31'h0, mRst});
  endtask

  task automatic cyc(input logic [5:0] a, input logic we, input logic [31:0] wd);
    busAddr = a; busWrite = we; busWdata = wd;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int pulses;
    rstN = 1'b0; gpioIn = 8'h5A; busAddr = 0; busWrite = 0; busWdata = 0;
    modelReset();
    // R2: reset defaults, read while reset is held
    cyc(6'd0, 0, 0);  check("R2 gpio in strap", busRdata, {24'h0, EXP_STRAP});
    cyc(6'd52, 0, 0); check("R2 cmd ready", busRdata, 32'h1);
    cyc(6'd56, 0, 0); check("R2 caps", busRdata, EXP_CAPS);
    cyc(6'd60, 0, 0); check("R2 system id", busRdata, EXP_ID);
    cyc(6'd16, 0, 0); check("R2 timer0 ctrl", busRdata, 32'h0);
    rstN = 1'b1;
    cyc(6'd0, 0, 0);  check("R3 gpio in sampled", busRdata, 32'h5A);
    cyc(6'd56, 1, 32'hFFFF_FFFF); check("R3 caps write ignored", busRdata, EXP_CAPS);
    // R4
    cyc(6'd4, 1, 32'hA5); check("R4 gpio out port", {24'h0, gpioOut}, 32'hA5);
    cyc(6'd4, 0, 0);      check("R4 gpio out read", busRdata, 32'hA5);
    // R5: pending from strap change, ack, new change, mask
    cyc(6'd8, 1, 32'hFF); check("R5 irq pending", {31'h0, gpioIrq}, 32'h1);
    cyc(6'd0, 1, 32'hFF); check("R5 irq acked", {31'h0, gpioIrq}, 32'h0);
    gpioIn = 8'h5B;
    cyc(6'd0, 0, 0);      check("R5 irq on change", {31'h0, gpioIrq}, 32'h1);
    cyc(6'd8, 1, 32'h0);  check("R5 irq masked", {31'h0, gpioIrq}, 32'h0);
    cyc(6'd0, 1, 32'hFF);
    // R1: reserved words and ignored low address bits
    cyc(6'd12, 1, 32'hDEAD_BEEF); check("R1 reserved 3", busRdata, 32'h0);
    cyc(6'd48, 1, 32'hDEAD_BEEF); check("R1 reserved 12", busRdata, 32'h0);
    cyc(6'd7, 0, 0); check("R1 low bits ignored", busRdata, 32'hA5);
    // R6 R7 R8: one-shot timer 0, compare 5
    cyc(6'd20, 1, 32'd5);
    cyc(6'd16, 1, 32'h1);
    for (int i = 1; i <= 6; i++) begin
      cyc(6'd24, 0, 0);
      if (i <= 5) check("R6 count step", busRdata, i);
    end
    check("R7 match pulse", {31'h0, timer0Irq}, 32'h1);
    check("R8 count back to zero", busRdata, 32'h0);
    cyc(6'd16, 0, 0);
    check("R8 enable cleared", busRdata, 32'h0);
    check("R7 pulse one cycle", {31'h0, timer0Irq}, 32'h0);
    // R9: auto-restart, compare 3, period 4
    cyc(6'd20, 1, 32'd3);
    cyc(6'd16, 1, 32'h3);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(6'd24, 0, 0);
      if (timer0Irq) pulses++;
    end
    check("R9 auto pulses", pulses, 32'd5);
    cyc(6'd16, 0, 0); check("R9 still enabled", busRdata, 32'h3);
    cyc(6'd16, 1, 32'h0);
    // R10: clipping on timer 1
    cyc(6'd36, 1, 32'd10);
    cyc(6'd40, 1, 32'd50); check("R10 clipped", busRdata, 32'd10);
    cyc(6'd40, 1, 32'd7);  check("R10 loaded", busRdata, 32'd7);
    cyc(6'd40, 0, 0);      check("R10 held while stopped", busRdata, 32'd7);
    // R11 and R12
    cyc(6'd52, 1, 32'hABCD_000E); check("R11 shutdown pulse", {31'h0, shutdownReq}, 32'h1);
    cyc(6'd52, 1, 32'h0000_000F); check("R11 no pulse", {31'h0, shutdownReq}, 32'h0);
    cyc(6'd60, 1, 32'h0);         check("R12 reset pulse", {31'h0, resetReq}, 32'h1);
    cyc(6'd60, 0, 0);
    check("R12 pulse ends", {31'h0, resetReq}, 32'h0);
    check("R12 id unchanged", busRdata, EXP_ID);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule